// File: doc/BRIEF.md
# Register Pending-Write Scoreboard

This block sits beside the issue stage of a small in-order RISC core. Some execution units run for many cycles: an iterative divider and a path that loads from external memory. Their results can come back after the results of later single-cycle instructions. The block keeps one pending-write bit per register. The bit is set when a long-running instruction issues and is cleared when that instruction's result comes back on the writeback port.

Each cycle the issue stage presents the decoded operand fields of the next instruction. These are two source registers, the data register of a store and a destination register, each with its own valid flag. The block answers with a combinational stall. Issue is held back in four cases:

- a read register is still waiting for a result;
- the destination is still waiting for an earlier result, so an instruction that only writes the register cannot overtake the earlier write;
- a divide would reuse the divider too soon;
- a divide reads a quotient that has not yet come back.

Top module: `regScoreboard`

## Requirements
- R1: The stall output is high while issueValid is high and either valid source register (srcA, srcB) has its pending bit set.
- R2: The data register of a store (storeReg, qualified by storeValid) is checked against pending bits in the same way as the source registers, and stalls issue when it is pending.
- R3: The stall output is high when dstValid is high and the destination register has a pending bit, even if the instruction reads no register. A write-only instruction therefore cannot overtake an earlier long-latency write to the same register.
- R4: An issued instruction with isLong low never sets a pending bit. A later instruction writing or reading the same register is not stalled because of it.
- R5: A writeback (wbValid with index wbReg) clears that register's pending bit at the clock edge ending the writeback cycle. An instruction reading that register stalls in the writeback cycle and is free on the next cycle.
- R6: An accepted instruction with isLong and dstValid high sets the pending bit of dstReg at the next edge, even when a writeback to another register happens in the same cycle. When set and clear target the same register in the same cycle, the clear is applied first, so the bit ends up set.
- R7: A divide that reads the quotient of an earlier divide stalls until that quotient has been written back.
- R8: The divider is busy from an accepted divide until the writeback flagged with wbDiv, and also for one further idle cycle after it. A divide (isDiv) presented while the divider is busy stalls, and two divides are never accepted on consecutive cycles.
- R9: With issueValid low, or with no valid register field and isDiv low, stall is low.
- R10: A synchronous reset (rst high at a clock edge) clears every pending bit and the divider-busy state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issueValid | input | 1 | An instruction is presented for issue |
| srcAValid | input | 1 | srcA is a register read |
| srcA | input | 5 | First source register index |
| srcBValid | input | 1 | srcB is a register read |
| srcB | input | 5 | Second source register index |
| storeValid | input | 1 | storeReg holds the data register of a store |
| storeReg | input | 5 | Store data register index |
| dstValid | input | 1 | The instruction writes dstReg |
| dstReg | input | 5 | Destination register index |
| isLong | input | 1 | The result returns later through the writeback port |
| isDiv | input | 1 | The instruction is a divide |
| wbValid | input | 1 | A long-latency result is written back this cycle |
| wbReg | input | 5 | Register index of the writeback |
| wbDiv | input | 1 | The writeback is the divider's quotient |
| stall | output | 1 | Hold the presented instruction this cycle |

## Verification
On every cycle, assertions check three things:

- an accepted long-latency write raises its pending bit;
- a writeback with no competing set clears its pending bit;
- a read of a pending source always produces a stall, and no divide is accepted in the cycle right after another divide or after a divider writeback.

Only the bench's scenarios can show some behaviour:

- the one-cycle delay before a waiting instruction is released;
- store-data and write-only destinations being held back while a divide is in flight;
- short instructions leaving no trace;
- a stalled divide not reserving anything;
- reset wiping the state mid-sequence.

// File: rtl/sbPkg.sv
package sbPkg;
  localparam int SB_REGS  = 32;
  localparam int SB_IDX_W = $clog2(SB_REGS);

  typedef logic [SB_IDX_W-1:0] regIdx_t;

  // strobes from control to the pending-bit datapath
  typedef struct packed {
    logic    setValid;
    regIdx_t setIdx;
    logic    clrValid;
    regIdx_t clrIdx;
  } sbStrobes_t;
endpackage

// File: rtl/sbPendingFile.sv
module sbPendingFile
  import sbPkg::*;
#(
  parameter int NUM_REGS = SB_REGS
) (
  input  logic                clk,
  input  logic                rst,
  input  sbStrobes_t          strobes,
  output logic [NUM_REGS-1:0] pendQ
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : gBit
    logic setHit;
    logic clrHit;
    assign setHit = strobes.setValid && (strobes.setIdx == regIdx_t'(g));
    assign clrHit = strobes.clrValid && (strobes.clrIdx == regIdx_t'(g));
    // clear is applied first, so a set in the same cycle wins
    always_ff @(posedge clk) begin
      if (rst)         pendQ[g] <= 1'b0;
      else if (setHit) pendQ[g] <= 1'b1;
      else if (clrHit) pendQ[g] <= 1'b0;
    end
  end

  // R5
  wb_clears_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.clrValid && !(strobes.setValid && strobes.setIdx == strobes.clrIdx))
      |=> !pendQ[$past(strobes.clrIdx)]);

  // R6
  issue_sets_pending_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.setValid |=> pendQ[$past(strobes.setIdx)]);

endmodule

// File: rtl/sbControl.sv
module sbControl
  import sbPkg::*;
#(
  parameter int NUM_REGS = SB_REGS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                issueValid,
  input  logic                srcAValid,
  input  regIdx_t             srcA,
  input  logic                srcBValid,
  input  regIdx_t             srcB,
  input  logic                storeValid,
  input  regIdx_t             storeReg,
  input  logic                dstValid,
  input  regIdx_t             dstReg,
  input  logic                isLong,
  input  logic                isDiv,
  input  logic                wbValid,
  input  regIdx_t             wbReg,
  input  logic                wbDiv,
  input  logic [NUM_REGS-1:0] pendQ,
  output logic                stall,
  output sbStrobes_t          strobes
);

  logic divBusy;
  logic divCool;
  logic rawHaz;
  logic wawHaz;
  logic divHaz;
  logic accept;
  logic divStart;
  logic divEnd;

  assign rawHaz = (srcAValid  && pendQ[srcA])
               || (srcBValid  && pendQ[srcB])
               || (storeValid && pendQ[storeReg]);
  assign wawHaz = dstValid && pendQ[dstReg];
  assign divHaz = isDiv && (divBusy || divCool);

  assign stall    = issueValid && (rawHaz || wawHaz || divHaz);
  assign accept   = issueValid && !stall;
  assign divStart = accept && isDiv;
  assign divEnd   = wbValid && wbDiv;

  always_comb begin
    strobes.setValid = accept && isLong && dstValid;
    strobes.setIdx   = dstReg;
    strobes.clrValid = wbValid;
    strobes.clrIdx   = wbReg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      divBusy <= 1'b0;
      divCool <= 1'b0;
    end else begin
      if (divStart)    divBusy <= 1'b1;
      else if (divEnd) divBusy <= 1'b0;
      divCool <= divEnd;
    end
  end

  // R8
  no_div_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    divStart |=> !divStart);

  // R8
  div_idle_gap_chk: assert property (@(posedge clk) disable iff (rst)
    divEnd |=> !divStart);

endmodule

// File: rtl/regScoreboard.sv
module regScoreboard
  import sbPkg::*;
#(
  parameter int NUM_REGS = SB_REGS,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issueValid,
  input  logic             srcAValid,
  input  logic [IDX_W-1:0] srcA,
  input  logic             srcBValid,
  input  logic [IDX_W-1:0] srcB,
  input  logic             storeValid,
  input  logic [IDX_W-1:0] storeReg,
  input  logic             dstValid,
  input  logic [IDX_W-1:0] dstReg,
  input  logic             isLong,
  input  logic             isDiv,
  input  logic             wbValid,
  input  logic [IDX_W-1:0] wbReg,
  input  logic             wbDiv,
  output logic             stall
);

  sbStrobes_t          strobes;
  logic [NUM_REGS-1:0] pendQ;

  sbControl #(.NUM_REGS(NUM_REGS)) i_ctrl (
    .clk(clk), .rst(rst), .issueValid(issueValid),
    .srcAValid(srcAValid), .srcA(srcA), .srcBValid(srcBValid), .srcB(srcB),
    .storeValid(storeValid), .storeReg(storeReg),
    .dstValid(dstValid), .dstReg(dstReg), .isLong(isLong), .isDiv(isDiv),
    .wbValid(wbValid), .wbReg(wbReg), .wbDiv(wbDiv),
    .pendQ(pendQ), .stall(stall), .strobes(strobes)
  );

  sbPendingFile #(.NUM_REGS(NUM_REGS)) i_pend (
    .clk(clk), .rst(rst), .strobes(strobes), .pendQ(pendQ)
  );

  // R1
  raw_src_stalls_chk: assert property (@(posedge clk) disable iff (rst)
    (issueValid && ((srcAValid && pendQ[srcA]) || (srcBValid && pendQ[srcB])))
      |-> stall);

  // R2
  store_data_stalls_chk: assert property (@(posedge clk) disable iff (rst)
    (issueValid && storeValid && pendQ[storeReg]) |-> stall);

endmodule

// File: tb/test_regScoreboard.sv
module test_regScoreboard;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic issueValid = 0, srcAValid = 0, srcBValid = 0, storeValid = 0;
  logic dstValid = 0, isLong = 0, isDiv = 0, wbValid = 0, wbDiv = 0;
  logic [4:0] srcA = 0, srcB = 0, storeReg = 0, dstReg = 0, wbReg = 0;
  logic stall;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  regScoreboard i_regScoreboard (
    .clk(clk), .rst(rst), .issueValid(issueValid),
    .srcAValid(srcAValid), .srcA(srcA), .srcBValid(srcBValid), .srcB(srcB),
    .storeValid(storeValid), .storeReg(storeReg),
    .dstValid(dstValid), .dstReg(dstReg), .isLong(isLong), .isDiv(isDiv),
    .wbValid(wbValid), .wbReg(wbReg), .wbDiv(wbDiv), .stall(stall)
  );

  typedef struct packed {
    logic wbV; logic [4:0] wbI; logic wbD;
    logic iv;
    logic aV; logic [4:0] a;
    logic bV; logic [4:0] b;
    logic sV; logic [4:0] s;
    logic dV; logic [4:0] d;
    logic lng; logic dv;
    logic exp;
    logic [3:0] req;
  } step_t;

  localparam int NSTEPS = 22;
  localparam step_t TBL [NSTEPS] = '{
    // wb          iv  srcA       srcB       store      dst        lng  dv   exp  req
    '{1'b0,5'd0,1'b0, 1'b1, 1'b1,5'd0, 1'b1,5'd2, 1'b0,5'd0, 1'b1,5'd1, 1'b1,1'b1, 1'b0, 4'd7},  // div r1
    '{1'b0,5'd0,1'b0, 1'b1, 1'b1,5'd1, 1'b1,5'd3, 1'b0,5'd0, 1'b1,5'd4, 1'b0,1'b0, 1'b1, 4'd1},  // R1 read r1
    '{1'b0,5'd0,1'b0, 1'b1, 1'b1,5'd14,1'b0,5'd0, 1'b1,5'd1, 1'b0,5'd0, 1'b0,1'b0, 1'b1, 4'd2},  // R2 store r1
    '{1'b0,5'd0,1'b0, 1'b1, 1'b0,5'd0, 1'b0,5'd0, 1'b0,5'd0, 1'b1,5'd1, 1'b0,1'b0, 1'b1, 4'd3},  // R3 move to r1
    '{1'b0,5'd0,1'b0, 1'b1, 1'b1,5'd5, 1'b1,5'd6, 1'b0,5'd0, 1'b1,5'd7, 1'b1,1'b1, 1'b1, 4'd8},  // R8 div busy
    '{1'b0,5'd0,1'b0, 1'b1, 1'b1,5'd3, 1'b1,5'd4, 1'b0,5'd0, 1'b1,5'd15,1'b0,1'b0, 1'b0, 4'd4},  // R4 short to r15
    '{1'b0,5'd0,1'b0, 1'b1, 1'b0,5'd0, 1'b0,5'd0, 1'b0,5'd0, 1'b1,5'd15,1'b0,1'b0, 1'b0, 4'd4},  // R4 move to r15
    '{1'b0,5'd0,1'b0, 1'b1, 1'b0,5'd0, 1'b0,5'd0, 1'b0,5'd0, 1'b0,5'd0, 1'b0,1'b0, 1'b0, 4'd9},  // R9 no operands
    '{1'b0,5'd0,1'b0, 1'b0, 1'b1,5'd1, 1'b0,5'd0, 1'b0,5'd0, 1'b0,5'd0, 1'b0,1'b0, 1'b0, 4'd9},  // R9 not valid
    '{1'b1,5'd1,1'b1, 1'b1, 1'b1,5'd1, 1'b0,5'd0, 1'b0,5'd0, 1'b0,5'd0, 1'b0,1'b0, 1'b1, 4'd5},  // R5 wb r1 same cycle
    '{1'b0,5'd0,1'b0, 1'b1, 1'b1,5'd5, 1'b1,5'd6, 1'b0,5'd0, 1'b1,5'd10,1'b1,1'b1, 1'b1, 4'd8},  // R8 idle gap
    '{1'b0,5'd0,1'b0, 1'b1, 1'b1,5'd1, 1'b0,5'd0, 1'b0,5'd0, 1'b0,5'd0, 1'b0,1'b0, 1'b0, 4'd5},  // R5 r1 free
    '{1'b0,5'd0,1'b0, 1'b1, 1'b1,5'd7, 1'b1,5'd10,1'b0,5'd0, 1'b0,5'd0, 1'b0,1'b0, 1'b0, 4'd6},  // R6 stalled divs left no mark
    '{1'b0,5'd0,1'b0, 1'b1, 1'b1,5'd1, 1'b1,5'd3, 1'b0,5'd0, 1'b1,5'd9, 1'b1,1'b1, 1'b0, 4'd8},  // R8 div after gap
    '{1'b0,5'd0,1'b0, 1'b1, 1'b1,5'd9, 1'b1,5'd3, 1'b0,5'd0, 1'b1,5'd20,1'b1,1'b1, 1'b1, 4'd7},  // R7 quotient pending
    '{1'b0,5'd0,1'b0, 1'b1, 1'b1,5'd2, 1'b0,5'd0, 1'b0,5'd0, 1'b1,5'd12,1'b1,1'b0, 1'b0, 4'd1},  // load r12
    '{1'b1,5'd12,1'b0,1'b1, 1'b1,5'd2, 1'b0,5'd0, 1'b0,5'd0, 1'b1,5'd13,1'b1,1'b0, 1'b0, 4'd6},  // R6 wb r12 + load r13
    '{1'b0,5'd0,1'b0, 1'b1, 1'b1,5'd12,1'b0,5'd0, 1'b0,5'd0, 1'b0,5'd0, 1'b0,1'b0, 1'b0, 4'd6},  // R6 r12 cleared
    '{1'b0,5'd0,1'b0, 1'b1, 1'b1,5'd3, 1'b1,5'd13,1'b0,5'd0, 1'b0,5'd0, 1'b0,1'b0, 1'b1, 4'd1},  // R1 srcB r13 pending
    '{1'b1,5'd9,1'b1, 1'b0, 1'b0,5'd0, 1'b0,5'd0, 1'b0,5'd0, 1'b0,5'd0, 1'b0,1'b0, 1'b0, 4'd5},  // R5 quotient r9 back
    '{1'b0,5'd0,1'b0, 1'b1, 1'b1,5'd9, 1'b1,5'd3, 1'b0,5'd0, 1'b1,5'd21,1'b1,1'b1, 1'b1, 4'd8},  // R8 gap after wb
    '{1'b0,5'd0,1'b0, 1'b1, 1'b1,5'd9, 1'b1,5'd3, 1'b0,5'd0, 1'b1,5'd21,1'b1,1'b1, 1'b0, 4'd7}   // R7 quotient ready
  };

  task automatic check(input logic exp, input string tag);
    checks++;
    if (stall !== exp) begin
      failures++;
      $display("FAIL %s stall actual=%b expected=%b", tag, stall, exp);
    end
  endtask

  task automatic drive(input step_t s);
    wbValid = s.wbV; wbReg = s.wbI; wbDiv = s.wbD;
    issueValid = s.iv;
    srcAValid = s.aV; srcA = s.a; srcBValid = s.bV; srcB = s.b;
    storeValid = s.sV; storeReg = s.s;
    dstValid = s.dV; dstReg = s.d; isLong = s.lng; isDiv = s.dv;
  endtask

  function automatic step_t idle();
    return '0;
  endfunction

  initial begin
    step_t st;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: after reset nothing is pending
    st = idle(); st.iv = 1; st.aV = 1; st.a = 5'd0; st.dV = 1; st.d = 5'd31;
    drive(st); #1 check(1'b0, "R10 reset state");
    for (int i = 0; i < NSTEPS; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      #1 check(TBL[i].exp, $sformatf("R%0d step %0d", TBL[i].req, i));
    end
    // r21 and r13 pending, divider busy; reset mid-sequence
    @(negedge clk);
    drive(idle());
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    st = idle(); st.iv = 1; st.aV = 1; st.a = 5'd21; st.bV = 1; st.b = 5'd13;
    drive(st); #1 check(1'b0, "R10 pending cleared");
    st = idle(); st.iv = 1; st.aV = 1; st.a = 5'd2; st.dV = 1; st.d = 5'd22;
    st.lng = 1; st.dv = 1;
    drive(st); #1 check(1'b0, "R10 divider freed");
    @(negedge clk);
    drive(idle());
    #1 check(1'b0, "R9 idle bus");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule